// File: doc/BRIEF.md
# DMA Channel Control and Drain Logic

This block is the control and status slice of one channel in a general-purpose DMA controller. It holds the channel's 32-bit configuration word, passes the selected source and destination peripheral request lines to the channel and blocks them when they do not apply, and buffers data in a small FIFO between the fetch side and the drain side. The bus master, the address generators and the arbiter are outside the block. They appear only as burst start and end strobes and as valid/ready handshakes on the FIFO.

Software shuts a channel down cleanly in three steps. It sets the halt bit, which stops new source requests and new FIFO writes. It then polls the read-only active bit until the remaining words have drained to the destination, and finally drops the channel enable. If enable is dropped while words remain, those words are discarded and active falls at once. When lock is set, a lock output covers each burst on its own, and it always drops for at least one cycle between a fetch burst and the drain burst that follows.

The FIFO interfaces use valid/ready handshakes. A word moves on a clock edge where both valid and ready are high. `push_ready` is low whenever the FIFO is full, the channel is disabled or halt is set. `pop_valid` is high only when the channel is enabled and the FIFO holds data. `pop_data` is held stable while `pop_valid` is high and `pop_ready` is low.

Top module: `dmacc_channel`

## Requirements
- R1: After reset the configuration reads 0. The word has these fields: source select in bits 4:1, destination select in bits 9:6, flow code in bits 13:11, error interrupt mask in bit 14, terminal-count interrupt mask in bit 15, lock in bit 16, active in bit 17 and halt in bit 18. Bits 0, 5, 10 and 31:19 always read 0, so writing all ones while the FIFO is empty reads back 0x0005FBDE.
- R2: Writes to bit 17 have no effect. Bit 17 reads 1 exactly when the channel is enabled and the FIFO holds at least one word.
- R3: The FIFO returns words in the order they were written and holds DEPTH words (default 4). `push_ready` is low when the FIFO is full, and `pop_valid` is low when it is empty.
- R4: While halt is 1, `push_ready` and `src_req_out` are low. Words already in the FIFO still drain through the pop interface until the FIFO is empty, and none is lost.
- R5: Clearing `chan_en` while the FIFO holds data makes active read 0 in the same cycle and discards the stored words. After the channel is enabled again, `pop_valid` stays low until a new word is written.
- R6: The flow code sets the transfer type and which side controls the flow: 0 memory to memory, 1 memory to peripheral, 2 peripheral to memory, 3 peripheral to peripheral, 4 peripheral to peripheral with the destination in control, 5 memory to peripheral with the destination in control, 6 peripheral to memory with the source in control, 7 peripheral to peripheral with the source in control. For codes 2, 3, 4, 6 and 7, `src_req_out` follows `src_req_in[source select]`. For codes 0, 1 and 5 it is 0.
- R7: For codes 1, 3, 4, 5 and 7, `dst_req_out` follows `dst_req_in[destination select]`. For codes 0, 2 and 6 it is 0.
- R8: With lock set, `bus_lock` goes high in the cycle after a `burst_start` pulse and goes low in the cycle after `burst_end`.
- R9: When `burst_end` and `burst_start` arrive in the same cycle with lock set, `bus_lock` is low for exactly one cycle and then goes high for the new burst.
- R10: With lock clear, a burst never raises `bus_lock`.
- R11: `tc_event` and `err_event` set `tc_flag` and `err_flag` whatever the masks are. `tc_clr` and `err_clr` clear the matching flag, and an event arriving in the same cycle as a clear wins.
- R12: `tc_irq` equals `tc_flag` AND the terminal-count mask, and `err_irq` equals `err_flag` AND the error mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable level |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_rd_data | output | 32 | Configuration read value, including active |
| src_req_in | input | NUM_PERIPH | Peripheral source request lines |
| dst_req_in | input | NUM_PERIPH | Peripheral destination request lines |
| src_req_out | output | 1 | Gated source request for the channel |
| dst_req_out | output | 1 | Gated destination request for the channel |
| push_valid | input | 1 | Fetched word valid |
| push_ready | output | 1 | FIFO accepts a word |
| push_data | input | DATA_W | Fetched word |
| pop_valid | output | 1 | Word available for drain |
| pop_ready | input | 1 | Drain side takes the word |
| pop_data | output | DATA_W | Word to drain |
| burst_start | input | 1 | Bus burst begins |
| burst_end | input | 1 | Bus burst ends |
| bus_lock | output | 1 | Bus lock request |
| tc_event | input | 1 | Terminal count reached |
| err_event | input | 1 | Bus error seen |
| tc_clr | input | 1 | Clear terminal-count flag |
| err_clr | input | 1 | Clear error flag |
| tc_flag | output | 1 | Terminal-count status |
| err_flag | output | 1 | Error status |
| tc_irq | output | 1 | Masked terminal-count interrupt |
| err_irq | output | 1 | Masked error interrupt |

## Verification
Two pairs of events can land in the same cycle. The first is the end of a locked fetch burst and the start of the drain burst. The bench pulses `burst_end` and `burst_start` together and checks that `bus_lock` drops for exactly one cycle before it rises again. The second is a status event and its clear strobe: `tc_event` and `tc_clr` are pulsed in the same cycle, and the flag must stay set. A scoreboard queue follows every accepted word, so a word lost during the halt drain shows up as a mismatch. A flush empties the queue to model the intended loss of data.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
  localparam int SEL_W  = 4;
  localparam int FLOW_W = 3;

  typedef struct packed {
    logic              halt;
    logic              lock;
    logic              tc_mask;
    logic              err_mask;
    logic [FLOW_W-1:0] flow;
    logic [SEL_W-1:0]  dst_sel;
    logic [SEL_W-1:0]  src_sel;
  } chan_cfg_t;

  // flow codes whose source side is a peripheral
  function automatic logic src_is_periph(input logic [FLOW_W-1:0] f);
    case (f)
      3'd2, 3'd3, 3'd4, 3'd6, 3'd7: src_is_periph = 1'b1;
      default:                      src_is_periph = 1'b0;
    endcase
  endfunction

  // flow codes whose destination side is a peripheral
  function automatic logic dst_is_periph(input logic [FLOW_W-1:0] f);
    case (f)
      3'd1, 3'd3, 3'd4, 3'd5, 3'd7: dst_is_periph = 1'b1;
      default:                      dst_is_periph = 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pack_cfg(input chan_cfg_t c, input logic act);
    logic [31:0] w;
    w        = '0;
    w[4:1]   = c.src_sel;
    w[9:6]   = c.dst_sel;
    w[13:11] = c.flow;
    w[14]    = c.err_mask;
    w[15]    = c.tc_mask;
    w[16]    = c.lock;
    w[17]    = act;
    w[18]    = c.halt;
    return w;
  endfunction
endpackage

// File: rtl/dmacc_cfg_reg.sv
module dmacc_cfg_reg
  import dmacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output chan_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      // bit 17 (active) and reserved bits are not stored
      cfg.src_sel  <= wr_data[4:1];
      cfg.dst_sel  <= wr_data[9:6];
      cfg.flow     <= wr_data[13:11];
      cfg.err_mask <= wr_data[14];
      cfg.tc_mask  <= wr_data[15];
      cfg.lock     <= wr_data[16];
      cfg.halt     <= wr_data[18];
    end
  end

  a_r1_reset_clean: assert property (@(posedge clk) !rst_n |=> cfg == '0);
endmodule

// File: rtl/dmacc_fifo.sv
module dmacc_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign full     = (count == FULLC);
  assign empty    = (count == '0);
  assign do_push  = push_en && !full;
  assign do_pop   = pop_en && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  a_r3_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop_en && !flush && !(push_en && $past(empty))) |=> $stable(pop_data));
endmodule

// File: rtl/dmacc_lock_ctrl.sv
module dmacc_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_en,
  input  logic burst_start,
  input  logic burst_end,
  output logic bus_lock
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_lock <= 1'b0;
      pend_q   <= 1'b0;
    end else if (burst_end) begin
      // release first; a burst starting now waits one cycle
      bus_lock <= 1'b0;
      pend_q   <= burst_start && lock_en;
    end else if (pend_q) begin
      bus_lock <= 1'b1;
      pend_q   <= 1'b0;
    end else if (burst_start && lock_en) begin
      bus_lock <= 1'b1;
    end
  end

  a_r9_release_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !bus_lock);
  a_r8_lock_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && lock_en && !burst_end) |=> bus_lock);
  a_r10_lock_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> ($past(lock_en) || $past(pend_q)));
endmodule

// File: rtl/dmacc_channel.sv
module dmacc_channel
  import dmacc_pkg::*;
#(
  parameter int NUM_PERIPH = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chan_en,
  input  logic                  cfg_wr_en,
  input  logic [31:0]           cfg_wr_data,
  output logic [31:0]           cfg_rd_data,
  input  logic [NUM_PERIPH-1:0] src_req_in,
  input  logic [NUM_PERIPH-1:0] dst_req_in,
  output logic                  src_req_out,
  output logic                  dst_req_out,
  input  logic                  push_valid,
  output logic                  push_ready,
  input  logic [DATA_W-1:0]     push_data,
  output logic                  pop_valid,
  input  logic                  pop_ready,
  output logic [DATA_W-1:0]     pop_data,
  input  logic                  burst_start,
  input  logic                  burst_end,
  output logic                  bus_lock,
  input  logic                  tc_event,
  input  logic                  err_event,
  input  logic                  tc_clr,
  input  logic                  err_clr,
  output logic                  tc_flag,
  output logic                  err_flag,
  output logic                  tc_irq,
  output logic                  err_irq
);
  localparam int SEL_SPAN = 1 << SEL_W;

  chan_cfg_t cfg;
  logic      fifo_full, fifo_empty, active;
  logic [SEL_SPAN-1:0] src_wide, dst_wide;

  dmacc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .cfg(cfg)
  );

  dmacc_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!chan_en),
    .push_en(push_valid && push_ready), .push_data(push_data),
    .pop_en(pop_valid && pop_ready), .pop_data(pop_data),
    .full(fifo_full), .empty(fifo_empty)
  );

  dmacc_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .lock_en(cfg.lock),
    .burst_start(burst_start), .burst_end(burst_end), .bus_lock(bus_lock)
  );

  // widen request lines to the full select range; unused selects read 0
  generate
    if (NUM_PERIPH >= SEL_SPAN) begin : g_req_trim
      assign src_wide = src_req_in[SEL_SPAN-1:0];
      assign dst_wide = dst_req_in[SEL_SPAN-1:0];
    end else begin : g_req_pad
      assign src_wide = {{(SEL_SPAN-NUM_PERIPH){1'b0}}, src_req_in};
      assign dst_wide = {{(SEL_SPAN-NUM_PERIPH){1'b0}}, dst_req_in};
    end
  endgenerate

  assign active      = chan_en && !fifo_empty;
  assign cfg_rd_data = pack_cfg(cfg, active);
  assign push_ready  = chan_en && !cfg.halt && !fifo_full;
  assign pop_valid   = active;
  assign src_req_out = chan_en && !cfg.halt && src_is_periph(cfg.flow) && src_wide[cfg.src_sel];
  assign dst_req_out = chan_en && dst_is_periph(cfg.flow) && dst_wide[cfg.dst_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (tc_event)     tc_flag <= 1'b1;
      else if (tc_clr)  tc_flag <= 1'b0;
      if (err_event)    err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  assign tc_irq  = tc_flag && cfg.tc_mask;
  assign err_irq = err_flag && cfg.err_mask;

  a_r4_halt_blocks_src: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.halt |-> (!src_req_out && !push_ready));
  a_r11_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tc_event |=> tc_flag);
  a_r11_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> err_flag);
  a_r2_active_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !cfg_rd_data[17]);
endmodule

// File: tb/test_dmacc_channel.sv
module test_dmacc_channel;
  localparam int NP = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, chan_en, cfg_wr_en, src_req_out, dst_req_out;
  logic [31:0] cfg_wr_data, cfg_rd_data;
  logic [NP-1:0] src_req_in, dst_req_in;
  logic push_valid, push_ready, pop_valid, pop_ready;
  logic [DW-1:0] push_data, pop_data;
  logic burst_start, burst_end, bus_lock;
  logic tc_event, err_event, tc_clr, err_clr, tc_flag, err_flag, tc_irq, err_irq;

  dmacc_channel #(.NUM_PERIPH(NP), .FIFO_DEPTH(4), .DATA_W(DW)) i_dmacc_channel (.*);

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] sb_q[$];

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: compares popped words against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1.5;
      if (rst_n && pop_valid && pop_ready) begin
        if (sb_q.size() == 0) chk(1'b0, "R3 unexpected pop", pop_data, 0);
        else begin
          logic [DW-1:0] e;
          e = sb_q.pop_front();
          chk(pop_data == e, "R3/R4 pop order", pop_data, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d; #1;
    if (push_ready) sb_q.push_back(d);
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  initial begin
    rst_n = 0; chan_en = 0; cfg_wr_en = 0; cfg_wr_data = 0;
    src_req_in = 0; dst_req_in = 0; push_valid = 0; pop_ready = 0; push_data = 0;
    burst_start = 0; burst_end = 0; tc_event = 0; err_event = 0; tc_clr = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(cfg_rd_data == 0, "R1 reset value", cfg_rd_data, 0);
    chk(bus_lock == 0 && tc_flag == 0 && err_flag == 0, "R1 reset outputs", {bus_lock, tc_flag, err_flag}, 0);

    // R1/R2: all-ones write, reserved and active read zero
    wr_cfg(32'hFFFF_FFFF); #1;
    chk(cfg_rd_data == 32'h0005_FBDE, "R1 R2 field mask", cfg_rd_data, 32'h0005_FBDE);
    wr_cfg(32'h0); // flow 0 memory to memory

    // R3: fill, full back-pressure, ordered drain
    @(negedge clk); chan_en = 1'b1;
    for (int i = 0; i < 4; i++) push_word(32'hA0 + i);
    #1;
    chk(push_ready == 0, "R3 full blocks push", push_ready, 0);
    chk(cfg_rd_data[17] == 1, "R2 active with data", cfg_rd_data[17], 1);
    push_word(32'hDEAD); // must be refused
    @(negedge clk); pop_ready = 1'b1;
    repeat (6) @(negedge clk);
    pop_ready = 1'b0; #1;
    chk(sb_q.size() == 0, "R3 all words drained", sb_q.size(), 0);
    chk(pop_valid == 0, "R3 empty no pop_valid", pop_valid, 0);
    chk(cfg_rd_data[17] == 0, "R2 active clear when empty", cfg_rd_data[17], 0);

    // R4: halt then drain, no loss
    wr_cfg(32'h0000_1000 | (32'd3 << 1)); // flow 2, src 3
    push_word(32'hB1); push_word(32'hB2);
    src_req_in = 16'h0008;
    wr_cfg(32'h0004_1000 | (32'd3 << 1)); #1;
    chk(src_req_out == 0, "R4 halt blocks src req", src_req_out, 0);
    chk(push_ready == 0, "R4 halt blocks push", push_ready, 0);
    chk(cfg_rd_data[17] == 1, "R4 active while draining", cfg_rd_data[17], 1);
    @(negedge clk); pop_ready = 1'b1;
    repeat (4) @(negedge clk);
    pop_ready = 1'b0; #1;
    chk(sb_q.size() == 0, "R4 halt drain no loss", sb_q.size(), 0);
    chk(cfg_rd_data[17] == 0, "R4 active drops after drain", cfg_rd_data[17], 0);
    @(negedge clk); chan_en = 1'b0; src_req_in = 0;
    wr_cfg(32'h0);

    // R5: disable with data discards it
    @(negedge clk); chan_en = 1'b1;
    push_word(32'hC1); push_word(32'hC2); push_word(32'hC3);
    @(negedge clk); chan_en = 1'b0; #1;
    chk(cfg_rd_data[17] == 0, "R5 active drops at once", cfg_rd_data[17], 0);
    sb_q.delete();
    @(negedge clk); chan_en = 1'b1; #1;
    chk(pop_valid == 0, "R5 flushed after re-enable", pop_valid, 0);

    // R6: source select gating
    wr_cfg((32'd2 << 11) | (32'd5 << 1));
    src_req_in = 16'h0020; #1;
    chk(src_req_out == 1, "R6 periph source passes", src_req_out, 1);
    src_req_in = 16'h0010; #1;
    chk(src_req_out == 0, "R6 other line ignored", src_req_out, 0);
    wr_cfg((32'd1 << 11) | (32'd5 << 1));
    src_req_in = 16'h0020; #1;
    chk(src_req_out == 0, "R6 memory source ignores select", src_req_out, 0);
    src_req_in = 0;

    // R7: destination select gating
    wr_cfg((32'd1 << 11) | (32'd9 << 6));
    dst_req_in = 16'h0200; #1;
    chk(dst_req_out == 1, "R7 periph dest passes", dst_req_out, 1);
    wr_cfg((32'd2 << 11) | (32'd9 << 6)); #1;
    chk(dst_req_out == 0, "R7 memory dest ignores select", dst_req_out, 0);
    dst_req_in = 0;

    // R8/R9: lock per burst
    wr_cfg(32'h0001_0000);
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0; #1;
    chk(bus_lock == 1, "R8 lock after start", bus_lock, 1);
    step();
    chk(bus_lock == 1, "R8 lock held in burst", bus_lock, 1);
    @(negedge clk); burst_end = 1; burst_start = 1;
    @(negedge clk); burst_end = 0; burst_start = 0; #1;
    chk(bus_lock == 0, "R9 gap between bursts", bus_lock, 0);
    step();
    chk(bus_lock == 1, "R9 relock for drain", bus_lock, 1);
    @(negedge clk); burst_end = 1;
    @(negedge clk); burst_end = 0; #1;
    chk(bus_lock == 0, "R8 release after end", bus_lock, 0);

    // R10: no lock bit
    wr_cfg(32'h0);
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0; #1;
    chk(bus_lock == 0, "R10 unlocked burst", bus_lock, 0);
    @(negedge clk); burst_end = 1;
    @(negedge clk); burst_end = 0;

    // R11/R12: flags and masks
    @(negedge clk); tc_event = 1; err_event = 1;
    @(negedge clk); tc_event = 0; err_event = 0; #1;
    chk(tc_flag == 1 && err_flag == 1, "R11 flags set while masked", {tc_flag, err_flag}, 2'b11);
    chk(tc_irq == 0 && err_irq == 0, "R12 masked irq low", {tc_irq, err_irq}, 0);
    wr_cfg(32'h0000_8000); #1;
    chk(tc_irq == 1 && err_irq == 0, "R12 tc mask opens", {tc_irq, err_irq}, 2'b10);
    wr_cfg(32'h0000_C000); #1;
    chk(err_irq == 1, "R12 err mask opens", err_irq, 1);
    @(negedge clk); tc_event = 1; tc_clr = 1;
    @(negedge clk); tc_event = 0; tc_clr = 0; #1;
    chk(tc_flag == 1, "R11 set wins over clear", tc_flag, 1);
    @(negedge clk); tc_clr = 1; err_clr = 1;
    @(negedge clk); tc_clr = 0; err_clr = 0; #1;
    chk(tc_flag == 0 && err_flag == 0, "R11 clear strobes", {tc_flag, err_flag}, 0);
    chk(tc_irq == 0 && err_irq == 0, "R12 irq follows flag", {tc_irq, err_irq}, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule